// File: doc/BRIEF.md
# Configurable Pin I/O Cell

This block sits between a programmable logic array and one group of package pins. On the way out, a selector picks one of four incoming logic-cell signals (A, B, C or the cell's register output Q). An optional inverter sits after the selector, and the result drives a three-state driver. The driver is modelled as a data output and a separate enable output, and the enable follows an output-enable input.

On the way in, the pin value returns to the array through a capture element. The element has three modes: an edge-triggered register, a level-sensitive transparent latch, or a bypass that passes the pin straight through. The capture clock is one of several global clock sources, chosen by a select input. The sources are sampled in the fabric clock domain. A register captures on the first fabric edge at which its selected source is seen high. A latch is transparent while the selected source is high. All lanes share the mode, source and clock settings.

Top module: `pin_io_cell`

## Requirements
- R1: `out_sel_i` picks the driven source per lane: 2'b00 gives A, 2'b01 gives B, 2'b10 gives C and 2'b11 gives Q.
- R2: With `out_inv_i`=1, `pad_o` is the bitwise inverse of the selected source. With `out_inv_i`=0, `pad_o` is the selected source unchanged.
- R3: Every bit of `pad_oe_o` equals `oe_i`. `pad_o` keeps showing the polarity-adjusted source while `oe_i` is 0.
- R4: `cap_mode_i` 2'b00 is bypass, and the reserved code 2'b11 acts the same way. In bypass, `fb_o` equals `pad_i` in the same cycle, with no clock edge needed.
- R5: In register mode (`cap_mode_i`=2'b01), `pad_i` is stored at a `clk_i` edge where the selected source is 1 and was 0 at the previous edge. The first edge after reset counts as a rise. `fb_o` shows the stored value after that edge.
- R6: In register mode, `fb_o` holds while the selected source stays high, stays low, or falls.
- R7: In latch mode (`cap_mode_i`=2'b10), `fb_o` follows `pad_i` in the same cycle while the selected source is 1.
- R8: In latch mode with the selected source at 0, `fb_o` holds the `pad_i` value sampled at the last `clk_i` edge where the source was 1.
- R9: `clk_sel_i` = k picks bit k of `clk_src_i` as the capture clock. The other bits have no effect on capture.
- R10: `rst_ni` low clears the stored value and the source history at once, asynchronously, so `fb_o` reads 0 in register mode.
- R11: The input path samples `pad_i` whatever the value of `oe_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lcc_a_i | input | W | Logic-cell signal A |
| lcc_b_i | input | W | Logic-cell signal B |
| lcc_c_i | input | W | Logic-cell signal C |
| lcc_q_i | input | W | Logic-cell register output Q |
| out_sel_i | input | 2 | Output source select |
| out_inv_i | input | 1 | Output polarity invert |
| oe_i | input | 1 | Output enable |
| pad_o | output | W | Driver data |
| pad_oe_o | output | W | Driver enable per lane |
| pad_i | input | W | Value seen at the pins |
| cap_mode_i | input | 2 | Capture mode select |
| clk_src_i | input | NCLK | Global capture clock sources |
| clk_sel_i | input | SELW | Capture clock select |
| fb_o | output | W | Input value fed back to the array |

## Verification
The assertions check the following on every cycle: the stored value after a detected rise in register mode, the hold between rises, the hold in latch mode while the source is low, the driver enable, and the bypass path. Other behaviours need the bench's ordered scenarios. These are the same-cycle transparency of the latch, the effect of sources that are not selected, a rise on the first edge after reset, and the clearing by reset in the middle of a run. The bench also covers capture while the driver is disabled, and the reserved mode code.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;
  typedef enum logic [1:0] {
    CAP_BYPASS = 2'b00,
    CAP_REG    = 2'b01,
    CAP_LATCH  = 2'b10,
    CAP_RSVD   = 2'b11
  } cap_mode_e;

  typedef enum logic [1:0] {
    SRC_A = 2'b00,
    SRC_B = 2'b01,
    SRC_C = 2'b10,
    SRC_Q = 2'b11
  } out_src_e;
endpackage

// File: rtl/pin_io_out_path.sv
module pin_io_out_path
  import pin_io_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] q_i,
  input  out_src_e     sel_i,
  input  logic         inv_i,
  input  logic         oe_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o
);
  for (genvar g = 0; g < W; g++) begin : g_lane
    logic src;
    always_comb begin
      unique case (sel_i)
        SRC_A:   src = a_i[g];
        SRC_B:   src = b_i[g];
        SRC_C:   src = c_i[g];
        default: src = q_i[g];
      endcase
    end
    assign pad_o[g]    = src ^ inv_i;
    assign pad_oe_o[g] = oe_i;
  end
endmodule

// File: rtl/pin_io_clk_sel.sv
module pin_io_clk_sel #(
  parameter int NCLK = 4,
  localparam int SELW = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCLK-1:0] src_i,
  input  logic [SELW-1:0] sel_i,
  output logic            lvl_o,
  output logic            rise_o
);
  logic lvl_q;

  assign lvl_o  = (int'(sel_i) < NCLK) ? src_i[sel_i] : 1'b0;
  assign rise_o = lvl_o & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_o;
  end

  // R5: a rise is never reported two edges in a row
  a_r5_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pin_io_capture.sv
module pin_io_capture
  import pin_io_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cap_mode_e    mode_i,
  input  logic         lvl_i,
  input  logic         rise_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] fb_o
);
  logic [W-1:0] cap_q;
  logic         load;

  always_comb begin
    unique case (mode_i)
      CAP_REG:   load = rise_i;
      CAP_LATCH: load = lvl_i;
      default:   load = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cap_q <= '0;
    else if (load) cap_q <= pad_i;
  end

  always_comb begin
    unique case (mode_i)
      CAP_REG:   fb_o = cap_q;
      CAP_LATCH: fb_o = lvl_i ? pad_i : cap_q;
      default:   fb_o = pad_i;
    endcase
  end

  // R5
  a_r5_reg_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CAP_REG && rise_i) |=> cap_q == $past(pad_i));
  // R6
  a_r6_reg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CAP_REG && !rise_i) |=> $stable(cap_q));
  // R8
  a_r8_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CAP_LATCH && !lvl_i) |=> $stable(cap_q));
endmodule

// File: rtl/pin_io_cell.sv
module pin_io_cell
  import pin_io_pkg::*;
#(
  parameter int W    = 4,
  parameter int NCLK = 4,
  localparam int SELW = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    lcc_a_i,
  input  logic [W-1:0]    lcc_b_i,
  input  logic [W-1:0]    lcc_c_i,
  input  logic [W-1:0]    lcc_q_i,
  input  logic [1:0]      out_sel_i,
  input  logic            out_inv_i,
  input  logic            oe_i,
  output logic [W-1:0]    pad_o,
  output logic [W-1:0]    pad_oe_o,
  input  logic [W-1:0]    pad_i,
  input  logic [1:0]      cap_mode_i,
  input  logic [NCLK-1:0] clk_src_i,
  input  logic [SELW-1:0] clk_sel_i,
  output logic [W-1:0]    fb_o
);
  logic cap_lvl, cap_rise;

  pin_io_out_path #(.W(W)) u_out (
    .a_i(lcc_a_i), .b_i(lcc_b_i), .c_i(lcc_c_i), .q_i(lcc_q_i),
    .sel_i(out_src_e'(out_sel_i)), .inv_i(out_inv_i), .oe_i(oe_i),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o)
  );

  pin_io_clk_sel #(.NCLK(NCLK)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(clk_src_i), .sel_i(clk_sel_i),
    .lvl_o(cap_lvl), .rise_o(cap_rise)
  );

  pin_io_capture #(.W(W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(cap_mode_e'(cap_mode_i)),
    .lvl_i(cap_lvl), .rise_i(cap_rise), .pad_i(pad_i), .fb_o(fb_o)
  );

  // R3
  a_r3_oe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o == {W{oe_i}});
  // R4
  a_r4_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i == 2'b00 || cap_mode_i == 2'b11) |-> fb_o == pad_i);
endmodule

// File: tb/pin_io_cell_bench.sv
module pin_io_cell_bench;
  localparam int CLK_P = 10;
  localparam int W = 4;
  localparam int NCLK = 4;
  localparam int NV = 6;
  // {sel, inv, oe, a, b, c, q, exp_pad, exp_oe}
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b1, 4'h3, 4'h5, 4'h9, 4'hE, 4'h3, 4'hF},
    {2'd1, 1'b0, 1'b1, 4'h3, 4'h5, 4'h9, 4'hE, 4'h5, 4'hF},
    {2'd2, 1'b1, 1'b1, 4'h3, 4'h5, 4'h9, 4'hE, 4'h6, 4'hF},
    {2'd3, 1'b0, 1'b0, 4'h3, 4'h5, 4'h9, 4'hE, 4'hE, 4'h0},
    {2'd3, 1'b1, 1'b1, 4'h3, 4'h5, 4'h9, 4'hE, 4'h1, 4'hF},
    {2'd0, 1'b1, 1'b0, 4'h3, 4'h5, 4'h9, 4'hE, 4'hC, 4'h0}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] a, b, c, q, pad_in, pad_out, pad_oe, fb;
  logic [1:0] out_sel, mode;
  logic inv, oe;
  logic [NCLK-1:0] src;
  logic [1:0] csel;
  int total = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  pin_io_cell #(.W(W), .NCLK(NCLK)) u_pin_io_cell (
    .clk_i(clk), .rst_ni(rst_ni), .lcc_a_i(a), .lcc_b_i(b), .lcc_c_i(c),
    .lcc_q_i(q), .out_sel_i(out_sel), .out_inv_i(inv), .oe_i(oe),
    .pad_o(pad_out), .pad_oe_o(pad_oe), .pad_i(pad_in), .cap_mode_i(mode),
    .clk_src_i(src), .clk_sel_i(csel), .fb_o(fb)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    {a, b, c, q, pad_in} = '0;
    out_sel = 2'd0; inv = 1'b0; oe = 1'b1;
    mode = 2'b01; src = '0; csel = 2'd2;
    pad_in = 4'hA;
    step(); step();
    chk("R10 reset clears", fb, 4'h0);
    rst_ni = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      {out_sel, inv, oe, a, b, c, q} = VEC[i][27:8];
      #1;
      chk("R1/R2 pad data", pad_out, VEC[i][7:4]);
      chk("R3 pad enable", pad_oe, VEC[i][3:0]);
    end
    oe = 1'b1;

    // register mode, source 2
    pad_in = 4'hA; src[2] = 1'b1;
    #1; chk("R5 no change before edge", fb, 4'h0);
    step(); chk("R5 rise capture", fb, 4'hA);
    pad_in = 4'h5; step();
    chk("R6 hold while high", fb, 4'hA);
    src[2] = 1'b0; step();
    chk("R6 hold on fall", fb, 4'hA);
    pad_in = 4'h6; src[2] = 1'b1; step();
    chk("R5 second rise", fb, 4'h6);
    src[2] = 1'b0; step();
    pad_in = 4'h9; src[1] = 1'b1; step();
    chk("R9 unselected source ignored", fb, 4'h6);
    csel = 2'd1; pad_in = 4'h3; step();
    chk("R9 reselect to source 1", fb, 4'h3);
    src = '0; step();

    // capture with driver disabled
    oe = 1'b0; pad_in = 4'hD; src[1] = 1'b1; step();
    chk("R11 capture with oe low", fb, 4'hD);
    src = '0; oe = 1'b1; step();

    // latch mode, source 0
    mode = 2'b10; csel = 2'd0;
    src[0] = 1'b1; pad_in = 4'h3; #1;
    chk("R7 latch transparent", fb, 4'h3);
    pad_in = 4'h7; #1;
    chk("R7 latch follows", fb, 4'h7);
    step();
    src[0] = 1'b0; pad_in = 4'h2; #1;
    chk("R8 latch holds low", fb, 4'h7);
    step(); pad_in = 4'h1; step();
    chk("R8 latch holds over edges", fb, 4'h7);
    src[3] = 1'b1; step();
    chk("R9 latch ignores other source", fb, 4'h7);
    src = '0;

    // bypass and reserved
    mode = 2'b00; pad_in = 4'hB; #1;
    chk("R4 bypass", fb, 4'hB);
    mode = 2'b11; pad_in = 4'h4; #1;
    chk("R4 reserved acts as bypass", fb, 4'h4);

    // async reset mid-run
    mode = 2'b01; step();
    #2 rst_ni = 1'b0; #1;
    chk("R10 async clear", fb, 4'h0);
    step(); rst_ni = 1'b1;
    src[0] = 1'b1; pad_in = 4'h8; step();
    chk("R5 first edge after reset is a rise", fb, 4'h8);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule